// File: doc/BRIEF.md
# Cluster Power Up/Down Sequencer

This block brings a cluster of cores that share an L2 cache into and out of power. It steps the cluster's control lines through a fixed order with timed gaps. The lines are the per-core resets, the per-core power-on resets, the cluster-level debug, trace and L2 resets, the L2 reset-disable line, the snoop-inactive line, the cluster and per-core power gates and the per-core power switches. Between steps it counts clock cycles. An external clock and voltage manager is asked to supply the cluster clock through a level request.

A sequence is started by a one-cycle request on `up_req` or `down_req` while the sequencer is idle. If the external power manager has not raised its ready flag, the request is refused and an error pulse is produced. Power-down first marks the cluster snoop-inactive and then waits for the L2 to report that it is idle. A cycle timeout turns that wait into an error if the L2 never reports. Each completed sequence ends with a one-cycle `done` pulse.

At reset the block assumes the cluster is running: all resets are released, all gates are open, all switches are on, the clock is requested and the L2 reset-disable line is high.

Top module: `cluster_pwr_seq`

## Requirements
- R1: A request seen while idle with `pm_ready` low gives an `err` pulse in the next cycle and changes no other output.
- R2: After reset, every reset output is 1 (all resets are active low), `l2_rst_dis`=1, `snoop_inact`=0, all gates are 0, all switches are 1, `clk_req`=1, and `done`=`err`=0.
- R3: An accepted power-up drives `core_rst_n` to 0 at the request edge. `core_por_n` goes to 0 GAP_S cycles later. All cluster resets (debug bus, trace, debug, L2) go to 0 GAP_S cycles after that.
- R4: GAP_S cycles after the cluster resets are asserted, power-up drives `l2_rst_dis` low and `clk_req` high. It then waits CLK_WAIT cycles.
- R5: Power-up then sets `snoop_inact` and clears `clus_gate` on the same edge. GAP_L cycles later it clears `snoop_inact` and releases the cluster resets. `done` pulses GAP_L cycles after that. Core and power-on resets stay at 0.
- R6: An accepted power-down sets `snoop_inact` at the request edge. It asserts no reset until `l2_wfi` has been sampled high.
- R7: The edge that samples `l2_wfi` high drives `core_rst_n` to 0. `core_por_n` follows GAP_S cycles later and the cluster resets follow GAP_S cycles after that.
- R8: GAP_S cycles after the cluster resets are asserted, `clus_gate` and every `core_gate` bit go to 1 together. GAP_L cycles later every `core_sw_en` bit goes to 0. One cycle after that, `clk_req` falls and `done` pulses.
- R9: If `l2_wfi` has not been sampled high by the WFI_TIMEOUT-th edge after the power-down request, `err` pulses on that edge, no reset is asserted and the block returns to idle. A high sample on that same edge still wins.
- R10: Requests that arrive during a sequence are ignored. When both requests arrive together while idle, power-up is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| up_req | input | 1 | Start power-up |
| down_req | input | 1 | Start power-down |
| pm_ready | input | 1 | External power manager ready |
| l2_wfi | input | 1 | L2 idle status |
| core_rst_n | output | NCORE | Per-core reset, active low |
| core_por_n | output | NCORE | Per-core power-on reset, active low |
| dbgbus_rst_n | output | 1 | Cluster debug-bus reset, active low |
| trace_rst_n | output | NCORE | Trace resets, active low |
| dbg_rst_n | output | NCORE | Debug resets, active low |
| l2_rst_n | output | 1 | L2 reset, active low |
| l2_rst_dis | output | 1 | L2 reset-disable line |
| snoop_inact | output | 1 | Snoop-inactive indication |
| clus_gate | output | 1 | Cluster power-off gate (1 = gated) |
| core_gate | output | NCORE | Per-core power-off gates (1 = gated) |
| core_sw_en | output | NCORE | Per-core power switch enable |
| clk_req | output | 1 | Cluster clock request to the external manager |
| done | output | 1 | Sequence complete pulse |
| err | output | 1 | Refused request or WFI timeout pulse |

## Verification
The bench builds the block with GAP_S=3, GAP_L=5, CLK_WAIT=8 and WFI_TIMEOUT=6. With these values every cycle of every sequence can be compared against an expected snapshot in a short run. The short timeout lets the bench place the L2 idle report exactly on the last allowed edge and also one edge too late, so both sides of the timeout are covered. Ignored requests and simultaneous requests are driven in the middle of and at the start of sequences.

// File: rtl/cluster_pwr_seq.sv
module cluster_pwr_seq #(
  parameter int NCORE       = 3,
  parameter int GAP_S       = 10,
  parameter int GAP_L       = 20,
  parameter int CLK_WAIT    = 1000,
  parameter int WFI_TIMEOUT = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_req,
  input  logic             down_req,
  input  logic             pm_ready,
  input  logic             l2_wfi,
  output logic [NCORE-1:0] core_rst_n,
  output logic [NCORE-1:0] core_por_n,
  output logic             dbgbus_rst_n,
  output logic [NCORE-1:0] trace_rst_n,
  output logic [NCORE-1:0] dbg_rst_n,
  output logic             l2_rst_n,
  output logic             l2_rst_dis,
  output logic             snoop_inact,
  output logic             clus_gate,
  output logic [NCORE-1:0] core_gate,
  output logic [NCORE-1:0] core_sw_en,
  output logic             clk_req,
  output logic             done,
  output logic             err
);
  localparam int M1   = (GAP_S > GAP_L) ? GAP_S : GAP_L;
  localparam int M2   = (CLK_WAIT > WFI_TIMEOUT) ? CLK_WAIT : WFI_TIMEOUT;
  localparam int TW   = $clog2(((M1 > M2) ? M1 : M2) + 1);
  localparam logic [TW-1:0] T_S  = TW'(GAP_S - 1);
  localparam logic [TW-1:0] T_L  = TW'(GAP_L - 1);
  localparam logic [TW-1:0] T_C  = TW'(CLK_WAIT - 1);
  localparam logic [TW-1:0] T_TO = TW'(WFI_TIMEOUT - 1);

  localparam logic [3:0] IDLE = 4'd0, U_CORE = 4'd1, U_POR = 4'd2, U_CLUS = 4'd3,
                         U_CLK = 4'd4, U_GATE = 4'd5, U_REL = 4'd6, D_WFI = 4'd7,
                         D_CORE = 4'd8, D_POR = 4'd9, D_CLUS = 4'd10, D_GATE = 4'd11,
                         D_SW = 4'd12;

  logic [3:0]    st;
  logic [TW-1:0] tmr;
  logic          clus_n;
  logic          idle, start;

  assign idle         = (st == IDLE);
  assign start        = idle && (up_req || down_req);
  assign dbgbus_rst_n = clus_n;
  assign l2_rst_n     = clus_n;
  assign trace_rst_n  = {NCORE{clus_n}};
  assign dbg_rst_n    = {NCORE{clus_n}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; tmr <= '0;
      core_rst_n <= '1; core_por_n <= '1; clus_n <= 1'b1;
      l2_rst_dis <= 1'b1; snoop_inact <= 1'b0;
      clus_gate <= 1'b0; core_gate <= '0; core_sw_en <= '1;
      clk_req <= 1'b1; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (st == IDLE) begin
        if (start) begin
          if (!pm_ready) err <= 1'b1;
          else if (up_req) begin
            core_rst_n <= '0; st <= U_CORE; tmr <= T_S;
          end else begin
            snoop_inact <= 1'b1; st <= D_WFI; tmr <= '0;
          end
        end
      end else if (st == D_WFI) begin
        if (l2_wfi) begin
          core_rst_n <= '0; st <= D_CORE; tmr <= T_S;
        end else if (tmr == T_TO) begin
          err <= 1'b1; st <= IDLE;
        end else tmr <= tmr + TW'(1);
      end else if (tmr != '0) begin
        tmr <= tmr - TW'(1);
      end else begin
        case (st)
          U_CORE: begin core_por_n <= '0; st <= U_POR; tmr <= T_S; end
          U_POR:  begin clus_n <= 1'b0; st <= U_CLUS; tmr <= T_S; end
          U_CLUS: begin l2_rst_dis <= 1'b0; clk_req <= 1'b1; st <= U_CLK; tmr <= T_C; end
          U_CLK:  begin snoop_inact <= 1'b1; clus_gate <= 1'b0; st <= U_GATE; tmr <= T_L; end
          U_GATE: begin snoop_inact <= 1'b0; clus_n <= 1'b1; st <= U_REL; tmr <= T_L; end
          U_REL:  begin done <= 1'b1; st <= IDLE; end
          D_CORE: begin core_por_n <= '0; st <= D_POR; tmr <= T_S; end
          D_POR:  begin clus_n <= 1'b0; st <= D_CLUS; tmr <= T_S; end
          D_CLUS: begin clus_gate <= 1'b1; core_gate <= '1; st <= D_GATE; tmr <= T_L; end
          D_GATE: begin core_sw_en <= '0; st <= D_SW; tmr <= '0; end
          D_SW:   begin clk_req <= 1'b0; done <= 1'b1; st <= IDLE; end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cluster_pwr_seq_chk.sv
module cluster_pwr_seq_chk #(parameter int NCORE = 3) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle,
  input logic             up_req,
  input logic             down_req,
  input logic             pm_ready,
  input logic [NCORE-1:0] core_rst_n,
  input logic [NCORE-1:0] core_por_n,
  input logic             l2_rst_n,
  input logic             l2_rst_dis,
  input logic             snoop_inact,
  input logic             clus_gate,
  input logic [NCORE-1:0] core_sw_en,
  input logic             clk_req,
  input logic             done,
  input logic             err
);
  assert_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    idle && (up_req || down_req) && !pm_ready |=> err);
  assert_por_after_core_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_por_n[0]) |-> core_rst_n == '0);
  assert_clus_after_por_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(l2_rst_n) |-> core_por_n == '0);
  assert_ungate_prep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clus_gate) |-> !l2_rst_dis && clk_req);
  assert_ungate_snoop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clus_gate) |-> snoop_inact);
  assert_release_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(l2_rst_n) |-> !snoop_inact && !clus_gate && core_rst_n == '0);
  assert_down_snoop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idle && down_req && !up_req && pm_ready |=> snoop_inact);
  assert_gate_after_reset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clus_gate) |-> core_rst_n == '0 && core_por_n == '0 && !l2_rst_n);
  assert_clk_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_req) |-> core_sw_en == '0 && done);
  assert_pulses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
endmodule

bind cluster_pwr_seq cluster_pwr_seq_chk #(.NCORE(NCORE)) chk_i (
  .clk(clk), .rst_n(rst_n), .idle(idle), .up_req(up_req), .down_req(down_req),
  .pm_ready(pm_ready), .core_rst_n(core_rst_n), .core_por_n(core_por_n),
  .l2_rst_n(l2_rst_n), .l2_rst_dis(l2_rst_dis), .snoop_inact(snoop_inact),
  .clus_gate(clus_gate), .core_sw_en(core_sw_en), .clk_req(clk_req),
  .done(done), .err(err));

// File: tb/cluster_pwr_seq_tb_top.sv
module cluster_pwr_seq_tb_top;
  localparam int N = 3, S = 3, L = 5, C = 8, T = 6;

  typedef struct packed {
    logic [N-1:0] core, por;
    logic clus, l2dis, snoop, cgate;
    logic [N-1:0] kgate, sw;
    logic clk, done, err;
  } ov_t;

  // scenario: [7:6] kind 0=up 1=down 2=both, [5] ready, [4] busy poke, [3:0] wfi delay
  localparam logic [7:0] SC [10] = '{
    {2'd0, 1'b0, 1'b0, 4'd0},   // R1 up refused
    {2'd1, 1'b0, 1'b0, 4'd0},   // R1 down refused
    {2'd1, 1'b1, 1'b0, 4'd0},   // R6 R7 R8 down, L2 already idle
    {2'd0, 1'b1, 1'b1, 4'd0},   // R3 R4 R5 up with ignored down (R10)
    {2'd1, 1'b1, 1'b0, 4'd3},   // R6 late L2 idle
    {2'd2, 1'b1, 1'b0, 4'd0},   // R10 both requests -> up
    {2'd1, 1'b1, 1'b0, 4'd15},  // R9 timeout, never idle
    {2'd0, 1'b1, 1'b0, 4'd0},   // up after timeout
    {2'd1, 1'b1, 1'b0, 4'(T-1)},// R9 idle on last allowed edge
    {2'd1, 1'b1, 1'b0, 4'(T)}   // R9 idle one edge late
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic up_req = 1'b0, down_req = 1'b0, pm_ready = 1'b1, l2_wfi = 1'b0;
  logic [N-1:0] core_rst_n, core_por_n, trace_rst_n, dbg_rst_n, core_gate, core_sw_en;
  logic dbgbus_rst_n, l2_rst_n, l2_rst_dis, snoop_inact, clus_gate, clk_req, done, err;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cluster_pwr_seq #(.NCORE(N), .GAP_S(S), .GAP_L(L), .CLK_WAIT(C), .WFI_TIMEOUT(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req), .pm_ready(pm_ready),
    .l2_wfi(l2_wfi), .core_rst_n(core_rst_n), .core_por_n(core_por_n),
    .dbgbus_rst_n(dbgbus_rst_n), .trace_rst_n(trace_rst_n), .dbg_rst_n(dbg_rst_n),
    .l2_rst_n(l2_rst_n), .l2_rst_dis(l2_rst_dis), .snoop_inact(snoop_inact),
    .clus_gate(clus_gate), .core_gate(core_gate), .core_sw_en(core_sw_en),
    .clk_req(clk_req), .done(done), .err(err));

  function automatic ov_t expect_at(int kind, bit rdy, int w, int k, ov_t p);
    ov_t e = p;
    int b;
    e.done = 0; e.err = 0;
    if (!rdy) begin
      if (k == 0) e.err = 1;
      return e;
    end
    if (kind != 1) begin
      e.core = '0;
      if (k >= S) e.por = '0;
      if (k >= 2*S) e.clus = 0;
      if (k >= 3*S) begin e.l2dis = 0; e.clk = 1; end
      if (k >= 3*S+C) begin e.snoop = 1; e.cgate = 0; end
      if (k >= 3*S+C+L) begin e.snoop = 0; e.clus = 1; end
      if (k == 3*S+C+2*L) e.done = 1;
    end else if (w >= T) begin
      e.snoop = 1;
      if (k == T) e.err = 1;
    end else begin
      b = 1 + w;
      e.snoop = 1;
      if (k >= b) e.core = '0;
      if (k >= b+S) e.por = '0;
      if (k >= b+2*S) e.clus = 0;
      if (k >= b+3*S) begin e.cgate = 1; e.kgate = '1; end
      if (k >= b+3*S+L) e.sw = '0;
      if (k >= b+3*S+L+1) e.clk = 0;
      if (k == b+3*S+L+1) e.done = 1;
    end
    return e;
  endfunction

  function automatic int seq_len(int kind, bit rdy, int w);
    if (!rdy) return 2;
    if (kind != 1) return 3*S+C+2*L+2;
    if (w >= T) return T+2;
    return w+3*S+L+4;
  endfunction

  task automatic check(string tag, int k, ov_t e);
    ov_t g;
    g = {core_rst_n, core_por_n, l2_rst_n, l2_rst_dis, snoop_inact, clus_gate,
         core_gate, core_sw_en, clk_req, done, err};
    checks++;
    if (g !== e || dbgbus_rst_n !== l2_rst_n || trace_rst_n !== {N{l2_rst_n}} ||
        dbg_rst_n !== {N{l2_rst_n}}) begin
      fails++;
      $display("FAIL %s k=%0d got=%b exp=%b", tag, k, g, e);
    end
  endtask

  initial begin
    ov_t prior;
    prior = '{core: '1, por: '1, clus: 1, l2dis: 1, snoop: 0, cgate: 0,
              kgate: '0, sw: '1, clk: 1, done: 0, err: 0};
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    check("R2 reset state", 0, prior);
    for (int i = 0; i < 10; i++) begin
      int kind, w, len;
      bit rdy, poke;
      string tag;
      kind = int'(SC[i][7:6]); rdy = SC[i][5]; poke = SC[i][4]; w = int'(SC[i][3:0]);
      len = seq_len(kind, rdy, w);
      if (!rdy) tag = "R1 refused";
      else if (kind == 2) tag = "R10 both requests";
      else if (kind == 0) tag = poke ? "R3/R4/R5 up, R10 busy" : "R3/R4/R5 up";
      else if (w >= T) tag = "R9 timeout";
      else tag = "R6/R7/R8 down";
      @(negedge clk);
      pm_ready = rdy;
      up_req = (kind != 1);
      down_req = (kind != 0);
      @(negedge clk);
      up_req = 0; down_req = 0;
      for (int k = 0; k < len; k++) begin
        check(tag, k, expect_at(kind, rdy, w, k, prior));
        down_req = poke && (k == 2);
        if (kind == 1 && rdy) l2_wfi = (k >= w);
        @(negedge clk);
      end
      down_req = 0; l2_wfi = 0; pm_ready = 1;
      prior = expect_at(kind, rdy, w, len, prior);
    end
    finished = 1;
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule